// File: doc/BRIEF.md
# Saturating Multi-Accumulator Multiply-Accumulate Unit

This block is a multiply-accumulate datapath that keeps a small bank of accumulators. Each command names one accumulator. A multiply-accumulate adds the product of two operands to that accumulator, and a multiply-subtract removes the product from it. A load writes a value straight into the accumulator, and a clear command resets the overflow status. Three mode inputs choose how the operands are read: as signed integers, as unsigned integers, or as signed fixed-point fractions. In fractional mode the product is doubled and then rescaled to the accumulator's width.

Each accumulator has its own sticky overflow flag. The flag is set when the product does not fit the accumulator's range, or when the running sum goes out of that range. Every multiply command also updates a general overflow flag from the destination's sticky flag. When saturation is enabled, an overflowing accumulator is forced to a limit value and then frozen. A frozen accumulator ignores further multiply commands until the flags are cleared or the accumulator is loaded. When saturation is disabled, the result wraps and only the flag records the overflow. All state is registered, so a command's effect appears at the outputs one clock after the edge that accepts it.

Top module: `mac_sat_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every accumulator reads 0, every sticky flag reads 0 and the general flag reads 0.
- R2: The command encoding is 0 no-op, 1 multiply-accumulate, 2 multiply-subtract, 3 load, 4 clear flags. In signed integer mode (frac_mode=0, unsigned_mode=0), command 1 adds op_a*op_b to the accumulator chosen by dst and command 2 subtracts it. Both operands are two's complement. The new value is visible one cycle later, and the other accumulators are unchanged.
- R3: In unsigned integer mode (frac_mode=0, unsigned_mode=1), the operands and the accumulator are read as unsigned values.
- R4: In fractional mode (frac_mode=1), the operands are signed and unsigned_mode is ignored. The added or subtracted term is floor(2*op_a*op_b / 2^OP_W).
- R5: The destination's sticky flag is set in three cases: the integer product falls outside the accumulator's range; in fractional mode, the product is at least 2^(2*OP_W-2), which happens only for the operands -1 and -1; or the sum or difference falls outside the accumulator's range (signed range in signed and fractional modes, 0 to 2^ACC_W-1 in unsigned mode). Once set, the flag stays set.
- R6: After a multiply command, the general flag equals the destination's sticky flag. Loads and no-ops leave the general flag unchanged.
- R7: Command 4 clears the general flag and all sticky flags, and removes every freeze. It leaves the accumulator values unchanged.
- R8: Command 3 writes load_data into the destination accumulator. It clears that accumulator's sticky flag and freeze, and leaves the general flag unchanged.
- R9: With saturation enabled in signed or fractional mode, an overflow forces 0x7FFF_FFFF on multiply-accumulate and 0x8000_0000 on multiply-subtract.
- R10: With saturation enabled in unsigned mode, an overflow forces 0xFFFF_FFFF on multiply-accumulate and 0x0000_0000 on multiply-subtract.
- R11: With saturation disabled, an overflowing result wraps to its low ACC_W bits.
- R12: An accumulator that has saturated ignores multiply commands, and its flag stays set, until a clear command or a load to that accumulator.
- R13: Command codes 5 to 7 change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (see R2) |
| dst | input | IDX_W | Destination accumulator index |
| op_a | input | OP_W | First multiplier operand |
| op_b | input | OP_W | Second multiplier operand |
| load_data | input | ACC_W | Value written by a load command |
| frac_mode | input | 1 | Selects fractional operands |
| unsigned_mode | input | 1 | Selects unsigned integer operands |
| sat_en | input | 1 | Enables saturation on overflow |
| acc_flat | output | NUM_ACC*ACC_W | All accumulators; accumulator i occupies bits [i*ACC_W +: ACC_W] |
| ovf_flags | output | NUM_ACC | Sticky overflow flag of each accumulator |
| v_flag | output | 1 | General overflow flag |

## Verification
The assertions relate each registered output to the command seen one cycle earlier, so they assume cmd, dst and load_data are stable and known at every rising edge outside reset. They also assume dst always names an existing accumulator. The bench changes inputs only on falling edges, holds cmd at the no-op code during reset, and draws dst only from the four valid indices. The saturation and freeze properties assume the mode inputs do not change between the command that causes an overflow and the result being observed, which the one-command-per-cycle stimulus respects.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_MAC  = 3'd1,
        CMD_MSU  = 3'd2,
        CMD_LOAD = 3'd3,
        CMD_CLRV = 3'd4
    } mac_cmd_e;

    typedef struct packed {
        logic frac;
        logic uns;
        logic sat;
    } mac_mode_t;

    function automatic logic is_accum_cmd(input mac_cmd_e c);
        return (c == CMD_MAC) || (c == CMD_MSU);
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int OP_W  = 32,
    parameter int ACC_W = 32,
    parameter int WIDE  = 2 * OP_W + 2
) (
    input  logic                   frac,
    input  logic                   uns,
    input  logic [OP_W-1:0]        a,
    input  logic [OP_W-1:0]        b,
    output logic signed [WIDE-1:0] term,
    output logic                   prod_ovf
);
    localparam logic signed [WIDE-1:0] SMAX = (WIDE'(1) <<< (ACC_W - 1)) - WIDE'(1);
    localparam logic signed [WIDE-1:0] SMIN = -(WIDE'(1) <<< (ACC_W - 1));
    localparam logic signed [WIDE-1:0] UMAX = (WIDE'(1) <<< ACC_W) - WIDE'(1);
    localparam logic signed [WIDE-1:0] FLIM = WIDE'(1) <<< (2 * OP_W - 2);

    logic                   zext;
    logic signed [WIDE-1:0] ea, eb, prod;

    assign zext = uns & ~frac;
    assign ea   = {{(WIDE-OP_W){a[OP_W-1] & ~zext}}, a};
    assign eb   = {{(WIDE-OP_W){b[OP_W-1] & ~zext}}, b};
    assign prod = ea * eb;

    always_comb begin
        if (frac) begin
            term     = prod >>> (OP_W - 1);
            prod_ovf = (prod >= FLIM);
        end else begin
            term     = prod;
            prod_ovf = zext ? (prod > UMAX) : ((prod > SMAX) || (prod < SMIN));
        end
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int WIDE  = 66
) (
    input  mac_mode_t              mode,
    input  logic                   sub,
    input  logic [ACC_W-1:0]       acc_old,
    input  logic signed [WIDE-1:0] term,
    input  logic                   prod_ovf,
    output logic [ACC_W-1:0]       result,
    output logic                   ovf,
    output logic                   sat_hit
);
    localparam logic signed [WIDE-1:0] SMAX = (WIDE'(1) <<< (ACC_W - 1)) - WIDE'(1);
    localparam logic signed [WIDE-1:0] SMIN = -(WIDE'(1) <<< (ACC_W - 1));
    localparam logic signed [WIDE-1:0] UMAX = (WIDE'(1) <<< ACC_W) - WIDE'(1);

    logic                   zext;
    logic signed [WIDE-1:0] ext, sum;
    logic                   range_ovf;
    logic [ACC_W-1:0]       limit;

    assign zext = mode.uns & ~mode.frac;
    assign ext  = {{(WIDE-ACC_W){acc_old[ACC_W-1] & ~zext}}, acc_old};
    assign sum  = sub ? (ext - term) : (ext + term);

    always_comb begin
        if (zext) begin
            range_ovf = (sum < 0) || (sum > UMAX);
            limit     = sub ? '0 : '1;
        end else begin
            range_ovf = (sum > SMAX) || (sum < SMIN);
            limit     = sub ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        end
    end

    assign ovf     = prod_ovf | range_ovf;
    assign sat_hit = ovf & mode.sat;
    assign result  = sat_hit ? limit : sum[ACC_W-1:0];
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
    parameter int NUM_ACC = 4,
    parameter int ACC_W   = 32,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_en,
    input  logic             ld_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] dst,
    input  logic [ACC_W-1:0] result,
    input  logic             ovf,
    input  logic             sat_hit,
    input  logic [ACC_W-1:0] load_data,
    output logic [ACC_W-1:0] acc_q [NUM_ACC],
    output logic [NUM_ACC-1:0] flag_q,
    output logic [NUM_ACC-1:0] frz_q
);
    for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
        logic sel;
        assign sel = (dst == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i]  <= '0;
                flag_q[i] <= 1'b0;
                frz_q[i]  <= 1'b0;
            end else if (clr_en) begin
                flag_q[i] <= 1'b0;
                frz_q[i]  <= 1'b0;
            end else if (ld_en && sel) begin
                acc_q[i]  <= load_data;
                flag_q[i] <= 1'b0;
                frz_q[i]  <= 1'b0;
            end else if (op_en && sel && !frz_q[i]) begin
                acc_q[i]  <= result;
                flag_q[i] <= flag_q[i] | ovf;
                frz_q[i]  <= sat_hit;
            end
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter  int OP_W    = 32,
    parameter  int ACC_W   = 32,
    parameter  int NUM_ACC = 4,
    localparam int IDX_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 cmd,
    input  logic [IDX_W-1:0]           dst,
    input  logic [OP_W-1:0]            op_a,
    input  logic [OP_W-1:0]            op_b,
    input  logic [ACC_W-1:0]           load_data,
    input  logic                       frac_mode,
    input  logic                       unsigned_mode,
    input  logic                       sat_en,
    output logic [NUM_ACC*ACC_W-1:0]   acc_flat,
    output logic [NUM_ACC-1:0]         ovf_flags,
    output logic                       v_flag
);
    localparam int WIDE = 2 * OP_W + 2;

    mac_cmd_e               cmd_e;
    mac_mode_t              mode;
    logic                   op_en, ld_en, clr_en;
    logic [ACC_W-1:0]       acc_q [NUM_ACC];
    logic [NUM_ACC-1:0]     flag_q, frz_q;
    logic signed [WIDE-1:0] term;
    logic                   prod_ovf, ovf, sat_hit;
    logic [ACC_W-1:0]       result;

    assign cmd_e  = mac_cmd_e'(cmd);
    assign op_en  = is_accum_cmd(cmd_e);
    assign ld_en  = (cmd_e == CMD_LOAD);
    assign clr_en = (cmd_e == CMD_CLRV);
    assign mode   = '{frac: frac_mode, uns: unsigned_mode, sat: sat_en};

    mac_product #(.OP_W(OP_W), .ACC_W(ACC_W), .WIDE(WIDE)) u_prod (
        .frac     (frac_mode),
        .uns      (unsigned_mode),
        .a        (op_a),
        .b        (op_b),
        .term     (term),
        .prod_ovf (prod_ovf)
    );

    mac_accum #(.ACC_W(ACC_W), .WIDE(WIDE)) u_accum (
        .mode     (mode),
        .sub      (cmd_e == CMD_MSU),
        .acc_old  (acc_q[dst]),
        .term     (term),
        .prod_ovf (prod_ovf),
        .result   (result),
        .ovf      (ovf),
        .sat_hit  (sat_hit)
    );

    mac_acc_bank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .op_en     (op_en),
        .ld_en     (ld_en),
        .clr_en    (clr_en),
        .dst       (dst),
        .result    (result),
        .ovf       (ovf),
        .sat_hit   (sat_hit),
        .load_data (load_data),
        .acc_q     (acc_q),
        .flag_q    (flag_q),
        .frz_q     (frz_q)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_en)
            v_flag <= 1'b0;
        else if (op_en)
            v_flag <= flag_q[dst] | (ovf & ~frz_q[dst]);
    end

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_out
        assign acc_flat[i*ACC_W +: ACC_W] = acc_q[i];
    end
    assign ovf_flags = flag_q;
endmodule

// File: rtl/mac_sat_checker.sv
module mac_sat_checker
    import mac_pkg::*;
#(
    parameter  int ACC_W   = 32,
    parameter  int NUM_ACC = 4,
    localparam int IDX_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic [2:0]               cmd,
    input logic [IDX_W-1:0]         dst,
    input logic [ACC_W-1:0]         load_data,
    input logic [NUM_ACC*ACC_W-1:0] acc_flat,
    input logic [NUM_ACC-1:0]       ovf_flags,
    input logic                     v_flag,
    input logic [NUM_ACC-1:0]       frz_q
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_flat == '0) && (ovf_flags == '0) && !v_flag);

    assert_v_from_dest_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd) == CMD_MAC || $past(cmd) == CMD_MSU) |-> (v_flag == ovf_flags[$past(dst)]));

    assert_clear_flags_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd) == CMD_CLRV) |-> (ovf_flags == '0) && !v_flag && (acc_flat == $past(acc_flat)));

    assert_load_write_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd) == CMD_LOAD) |->
            (acc_flat[$past(dst)*ACC_W +: ACC_W] == $past(load_data)) &&
            !ovf_flags[$past(dst)] && (v_flag == $past(v_flag)));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd) == CMD_MAC || $past(cmd) == CMD_MSU) |->
            (($past(ovf_flags) & ~ovf_flags) == '0));

    assert_frozen_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (($past(cmd) == CMD_MAC || $past(cmd) == CMD_MSU) && $past(frz_q[dst])) |->
            (acc_flat == $past(acc_flat)) && (ovf_flags == $past(ovf_flags)));

    assert_unused_codes_R13: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd) > 3'd4) |->
            (acc_flat == $past(acc_flat)) && (ovf_flags == $past(ovf_flags)) &&
            (v_flag == $past(v_flag)));
endmodule

bind mac_sat_unit mac_sat_checker #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .dst       (dst),
    .load_data (load_data),
    .acc_flat  (acc_flat),
    .ovf_flags (ovf_flags),
    .v_flag    (v_flag),
    .frz_q     (frz_q)
);

// File: tb/mac_sat_unit_bench.sv
module mac_sat_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  dst = 2'd0;
    logic [31:0] op_a = '0, op_b = '0, load_data = '0;
    logic        frac_mode = 1'b0, unsigned_mode = 1'b0, sat_en = 1'b0;
    logic [127:0] acc_flat;
    logic [3:0]  ovf_flags;
    logic        v_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mac_sat_unit u_mac_sat_unit (
        .clk(clk), .rst(rst), .cmd(cmd), .dst(dst), .op_a(op_a), .op_b(op_b),
        .load_data(load_data), .frac_mode(frac_mode), .unsigned_mode(unsigned_mode),
        .sat_en(sat_en), .acc_flat(acc_flat), .ovf_flags(ovf_flags), .v_flag(v_flag)
    );

    typedef struct packed {
        logic [2:0]  cmd;
        logic [1:0]  dst;
        logic [31:0] a;
        logic [31:0] b;
        logic        frac;
        logic        uns;
        logic        sat;
        logic [31:0] eacc;
        logic        eflag;
        logic        ev;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    // cmd: 0 nop, 1 mac, 2 msu, 3 load, 4 clear; a doubles as load value
    localparam vec_t VEC [NV] = '{
        '{3'd3, 2'd0, 32'd100,        32'd0,        1'b0,1'b0,1'b1, 32'd100,        1'b0,1'b0, 4'd8},  // R8
        '{3'd1, 2'd0, 32'd3,          32'hFFFFFFFC, 1'b0,1'b0,1'b1, 32'd88,         1'b0,1'b0, 4'd2},  // R2
        '{3'd2, 2'd0, 32'd5,          32'd6,        1'b0,1'b0,1'b1, 32'd58,         1'b0,1'b0, 4'd2},  // R2
        '{3'd1, 2'd1, 32'h00010000,   32'h00008000, 1'b0,1'b0,1'b1, 32'h7FFFFFFF,   1'b1,1'b1, 4'd9},  // R9
        '{3'd1, 2'd1, 32'd1,          32'd1,        1'b0,1'b0,1'b1, 32'h7FFFFFFF,   1'b1,1'b1, 4'd12}, // R12
        '{3'd1, 2'd0, 32'd1,          32'd1,        1'b0,1'b0,1'b1, 32'd59,         1'b0,1'b0, 4'd6},  // R6
        '{3'd4, 2'd1, 32'd0,          32'd0,        1'b0,1'b0,1'b1, 32'h7FFFFFFF,   1'b0,1'b0, 4'd7},  // R7
        '{3'd2, 2'd1, 32'd1,          32'd1,        1'b0,1'b0,1'b1, 32'h7FFFFFFE,   1'b0,1'b0, 4'd12}, // R12
        '{3'd3, 2'd2, 32'h7FFFFFF0,   32'd0,        1'b0,1'b0,1'b0, 32'h7FFFFFF0,   1'b0,1'b0, 4'd8},  // R8
        '{3'd1, 2'd2, 32'h10,         32'd1,        1'b0,1'b0,1'b0, 32'h80000000,   1'b1,1'b1, 4'd11}, // R11
        '{3'd1, 2'd2, 32'd1,          32'd1,        1'b0,1'b0,1'b0, 32'h80000001,   1'b1,1'b1, 4'd5},  // R5
        '{3'd3, 2'd2, 32'd5,          32'd0,        1'b0,1'b0,1'b1, 32'd5,          1'b0,1'b1, 4'd8},  // R8
        '{3'd3, 2'd3, 32'd10,         32'd0,        1'b0,1'b1,1'b1, 32'd10,         1'b0,1'b1, 4'd8},  // R8
        '{3'd2, 2'd3, 32'd3,          32'd4,        1'b0,1'b1,1'b1, 32'd0,          1'b1,1'b1, 4'd10}, // R10
        '{3'd3, 2'd3, 32'hFFFFFFF0,   32'd0,        1'b0,1'b1,1'b1, 32'hFFFFFFF0,   1'b0,1'b1, 4'd8},  // R8
        '{3'd1, 2'd3, 32'h20,         32'd1,        1'b0,1'b1,1'b1, 32'hFFFFFFFF,   1'b1,1'b1, 4'd10}, // R10
        '{3'd3, 2'd3, 32'd0,          32'd0,        1'b0,1'b1,1'b1, 32'd0,          1'b0,1'b1, 4'd8},  // R8
        '{3'd1, 2'd3, 32'hFFFFFFFF,   32'd1,        1'b0,1'b1,1'b1, 32'hFFFFFFFF,   1'b0,1'b0, 4'd3},  // R3
        '{3'd3, 2'd0, 32'd0,          32'd0,        1'b1,1'b0,1'b1, 32'd0,          1'b0,1'b0, 4'd8},  // R8
        '{3'd1, 2'd0, 32'h40000000,   32'h40000000, 1'b1,1'b0,1'b1, 32'h20000000,   1'b0,1'b0, 4'd4},  // R4
        '{3'd2, 2'd0, 32'h80000000,   32'h40000000, 1'b1,1'b1,1'b1, 32'h60000000,   1'b0,1'b0, 4'd4},  // R4
        '{3'd1, 2'd0, 32'h80000000,   32'h80000000, 1'b1,1'b0,1'b1, 32'h7FFFFFFF,   1'b1,1'b1, 4'd5},  // R5
        '{3'd3, 2'd1, 32'h80000005,   32'd0,        1'b0,1'b0,1'b1, 32'h80000005,   1'b0,1'b1, 4'd8},  // R8
        '{3'd2, 2'd1, 32'd3,          32'd3,        1'b0,1'b0,1'b1, 32'h80000000,   1'b1,1'b1, 4'd9},  // R9
        '{3'd2, 2'd1, 32'd1,          32'd1,        1'b0,1'b0,1'b1, 32'h80000000,   1'b1,1'b1, 4'd12}, // R12
        '{3'd0, 2'd1, 32'd7,          32'd7,        1'b0,1'b0,1'b1, 32'h80000000,   1'b1,1'b1, 4'd6},  // R6
        '{3'd3, 2'd3, 32'd2,          32'd0,        1'b0,1'b1,1'b0, 32'd2,          1'b0,1'b1, 4'd8},  // R8
        '{3'd2, 2'd3, 32'd1,          32'd3,        1'b0,1'b1,1'b0, 32'hFFFFFFFF,   1'b1,1'b1, 4'd11}, // R11
        '{3'd1, 2'd2, 32'hFFFFFFFF,   32'hFFFFFFFF, 1'b0,1'b0,1'b1, 32'd6,          1'b0,1'b0, 4'd2},  // R2
        '{3'd3, 2'd2, 32'd0,          32'd0,        1'b0,1'b1,1'b1, 32'd0,          1'b0,1'b0, 4'd8},  // R8
        '{3'd1, 2'd2, 32'h00010000,   32'h00010000, 1'b0,1'b1,1'b1, 32'hFFFFFFFF,   1'b1,1'b1, 4'd5}   // R5
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [1:0] d, input logic [31:0] a,
                         input logic [31:0] b, input logic fr, input logic un, input logic sa);
        cmd = c; dst = d; op_a = a; op_b = b; load_data = a;
        frac_mode = fr; unsigned_mode = un; sat_en = sa;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [127:0] snap_acc;
        logic [3:0]   snap_flags;
        logic         snap_v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state visible on first cycle after reset
        check("R1 accumulators", acc_flat, '0);
        check("R1 sticky flags", 128'(ovf_flags), '0);
        check("R1 general flag", 128'(v_flag), '0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cmd, VEC[i].dst, VEC[i].a, VEC[i].b, VEC[i].frac, VEC[i].uns, VEC[i].sat);
            check($sformatf("R%0d row %0d acc", VEC[i].req, i),
                  128'(acc_flat[VEC[i].dst*32 +: 32]), 128'(VEC[i].eacc));
            check($sformatf("R%0d row %0d flag", VEC[i].req, i),
                  128'(ovf_flags[VEC[i].dst]), 128'(VEC[i].eflag));
            check($sformatf("R%0d row %0d v", VEC[i].req, i), 128'(v_flag), 128'(VEC[i].ev));
        end

        // R13: unused command codes leave every output untouched
        snap_acc = acc_flat; snap_flags = ovf_flags; snap_v = v_flag;
        drive(3'd5, 2'd1, 32'd9, 32'd9, 1'b0, 1'b0, 1'b0);
        drive(3'd7, 2'd0, 32'd9, 32'd9, 1'b0, 1'b0, 1'b0);
        check("R13 accumulators", acc_flat, snap_acc);
        check("R13 flags", 128'(ovf_flags), 128'(snap_flags));
        check("R13 general flag", 128'(v_flag), 128'(snap_v));

        // R7: clear drops all flags, accumulators keep values
        drive(3'd4, 2'd0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b1);
        check("R7 all flags cleared", 128'(ovf_flags), '0);
        check("R7 accumulators kept", acc_flat, snap_acc);

        // R12: after clear the previously frozen accumulator 1 accepts work again
        // R2: other accumulators unchanged
        drive(3'd1, 2'd1, 32'd1, 32'd1, 1'b0, 1'b0, 1'b1);
        check("R12 unfrozen acc1", 128'(acc_flat[63:32]), 128'(32'h80000001));
        check("R2 acc0 untouched", 128'(acc_flat[31:0]), 128'(snap_acc[31:0]));
        check("R2 acc3 untouched", 128'(acc_flat[127:96]), 128'(snap_acc[127:96]));

        done = 1'b1;
        finish_run();
    end
endmodule